// File: doc/BRIEF.md
# 66-bit Block Stream Source with Alignment-Marker Scheduling

This block is the client-side transmit source that hands 66-bit encoded blocks to a downstream PCS sink. It can be built for one block per cycle or for four blocks packed into a 264-bit word. The sink raises `snk_ready` to show that it can take data. The block answers with `snk_valid`, which is the same ready pattern delayed by a fixed number of cycles set at configuration time. Back-pressure therefore works through the delay line only. When valid is low, the data bus holds its last value and nothing is consumed upstream.

The block counts valid cycles to schedule alignment-marker gaps. On a fixed number of valid cycles at the start of every period, it raises `snk_am`. On those cycles the sink ignores the data bus, so no upstream word is taken. Upstream words arrive on a first-word-fall-through pop interface (`src_data`, `src_empty`, `src_pop`). If a data slot falls due while the upstream side is empty, the block sends idle control blocks in place of data and sets a sticky error flag. The latency, period and burst length are taken from the configuration inputs only while the block is disabled.

Top module: `tx66_blk_source`

## Requirements
- R1: Lane k of a word occupies bits [66k+65:66k], and lane 0 is transmitted first. Each 66-bit block passes through unchanged, with its 2-bit sync header in bits [1:0].
- R2: While the block is enabled, `snk_valid` equals `snk_ready` delayed by L cycles. L is the latency value captured from `cfg_latency`, clamped so that 0 becomes 1 and any value above MAX_LAT becomes MAX_LAT.
- R3: In any cycle where `snk_valid` is low, `snk_data` keeps the value it had in the previous cycle, and `src_pop` stays low.
- R4: The marker counter starts at 0. It advances by one on each valid cycle and wraps to 0 after reaching period−1. It holds its value on cycles where valid is low. `snk_am` is high exactly when the counter is below the burst length.
- R5: While `en` is low, `snk_valid` is low, the counter is held at 0 (so `snk_am` is high), and the delay line is cleared.
- R6: `src_pop` is high exactly when valid is high, `snk_am` is low and `src_empty` is low. In that cycle, `snk_data` equals `src_data` in the same cycle.
- R7: On valid cycles where `snk_am` is high, `snk_data` holds its previous value and no word is popped.
- R8: If a data slot (valid high, `snk_am` low) arrives while `src_empty` is high, every lane carries the idle block `{56'h0, 8'h1E, 2'b10}`. `err_underflow` is then set and stays high until reset.
- R9: Latency, period and burst are captured only in cycles where `en` is low. Changing the configuration inputs while enabled has no effect.
- R10: During reset, `snk_valid`, `src_pop` and `err_underflow` are low, `snk_data` is zero, and `snk_am` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; configuration is captured while low |
| cfg_latency | input | LAT_W | Ready-to-valid delay in cycles (1..MAX_LAT) |
| cfg_period | input | PER_W | Marker period in valid cycles |
| cfg_burst | input | BURST_W | Marker flag length in valid cycles |
| src_data | input | 66*LANES | Upstream word at the head of the queue |
| src_empty | input | 1 | Upstream queue has no word |
| src_pop | output | 1 | Consume the head word this cycle |
| snk_ready | input | 1 | Sink can accept data |
| snk_valid | output | 1 | Delayed copy of ready; data is valid |
| snk_data | output | 66*LANES | Block word to the sink |
| snk_am | output | 1 | Alignment-marker gap flag |
| err_underflow | output | 1 | Sticky: a data slot found the upstream empty |

## Verification
The bench builds the block with four lanes and MAX_LAT of 10, and shrinks the marker period through the configuration inputs instead of the parameter. Every latency from 0 to 12 is swept, which reaches both clamp edges. Periods of 9, 2 and 315 valid cycles are used, with burst lengths of 1 and 5, so that many complete marker periods and wraps happen in a few thousand cycles. The ready and empty patterns include gaps that land inside marker bursts and underflows on data slots. A separate run changes the configuration inputs in the middle of an enabled run.

// File: rtl/tx66_pkg.sv
package tx66_pkg;
  localparam int BLK_W = 66;
  typedef logic [BLK_W-1:0] blk_t;

  // Idle control block: sync header 2'b10, block type 0x1E, all idle characters.
  function automatic blk_t idle_blk();
    return {56'h0, 8'h1E, 2'b10};
  endfunction
endpackage

// File: rtl/tx66_rdy_delay.sv
module tx66_rdy_delay #(
  parameter int MAX_LAT = 10,
  parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ready,
  input  logic [LAT_W-1:0] lat,
  output logic             valid
);
  logic [MAX_LAT-1:0] hist;
  logic               tap;

  generate
    if (MAX_LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist <= '0;
        else if (!en) hist <= '0;
        else          hist <= ready;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist <= '0;
        else if (!en) hist <= '0;
        else          hist <= {hist[MAX_LAT-2:0], ready};
      end
    end
  endgenerate

  always_comb begin
    tap = 1'b0;
    for (int i = 0; i < MAX_LAT; i++)
      if (lat == LAT_W'(i + 1)) tap = hist[i];
  end

  assign valid = en & tap;

  // R2: with a one-cycle delay, valid repeats last cycle's ready
  p_lat1_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && en && lat == LAT_W'(1) && $past(lat) == LAT_W'(1))
      |-> (valid == $past(ready)));
endmodule

// File: rtl/tx66_am_sched.sv
module tx66_am_sched #(
  parameter int PER_W   = 17,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               adv,
  input  logic [PER_W-1:0]   per,
  input  logic [BURST_W-1:0] burst,
  output logic               am
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] burst_ext;

  assign burst_ext = {{(PER_W-BURST_W){1'b0}}, burst};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (adv)     cnt <= (cnt == per - PER_W'(1)) ? '0 : cnt + PER_W'(1);
  end

  assign am = (cnt < burst_ext);

  // R4: counter frozen on non-valid cycles
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv) |=> $stable(cnt));
  // R4: wrap after the last position of the period
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && cnt == per - PER_W'(1)) |=> (cnt == '0));
  // R5: disabled means counter at zero next cycle
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/tx66_blk_mux.sv
module tx66_blk_mux
  import tx66_pkg::*;
#(
  parameter int LANES = 4,
  localparam int W    = BLK_W * LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot,
  input  logic         empty,
  input  logic [W-1:0] src_data,
  output logic [W-1:0] data,
  output logic         pop,
  output logic         err
);
  logic [W-1:0] idle_w;
  logic [W-1:0] hold_q;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign idle_w[k*BLK_W +: BLK_W] = idle_blk();
    end
  endgenerate

  assign data = slot ? (empty ? idle_w : src_data) : hold_q;
  assign pop  = slot & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      err    <= 1'b0;
    end else begin
      hold_q <= data;
      if (slot && empty) err <= 1'b1;
    end
  end

  // R8: underflow flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/tx66_blk_source.sv
module tx66_blk_source
  import tx66_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int MAX_LAT   = 10,
  parameter int PER_W     = 17,
  parameter int BURST_W   = 4,
  parameter int DEF_LAT   = 1,
  parameter int DEF_PER   = 81915,
  parameter int DEF_BURST = 5,
  localparam int LAT_W    = $clog2(MAX_LAT + 1),
  localparam int W        = BLK_W * LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [LAT_W-1:0]   cfg_latency,
  input  logic [PER_W-1:0]   cfg_period,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [W-1:0]       src_data,
  input  logic               src_empty,
  output logic               src_pop,
  input  logic               snk_ready,
  output logic               snk_valid,
  output logic [W-1:0]       snk_data,
  output logic               snk_am,
  output logic               err_underflow
);
  logic [LAT_W-1:0]   lat_q, lat_clamp;
  logic [PER_W-1:0]   per_q;
  logic [BURST_W-1:0] burst_q;
  logic               slot;

  always_comb begin
    if (cfg_latency == '0)                     lat_clamp = LAT_W'(1);
    else if (cfg_latency > LAT_W'(MAX_LAT))    lat_clamp = LAT_W'(MAX_LAT);
    else                                       lat_clamp = cfg_latency;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= LAT_W'(DEF_LAT);
      per_q   <= PER_W'(DEF_PER);
      burst_q <= BURST_W'(DEF_BURST);
    end else if (!en) begin
      lat_q   <= lat_clamp;
      per_q   <= cfg_period;
      burst_q <= cfg_burst;
    end
  end

  tx66_rdy_delay #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .ready (snk_ready),
    .lat   (lat_q),
    .valid (snk_valid)
  );

  tx66_am_sched #(.PER_W(PER_W), .BURST_W(BURST_W)) u_sched (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .adv   (snk_valid),
    .per   (per_q),
    .burst (burst_q),
    .am    (snk_am)
  );

  assign slot = snk_valid & ~snk_am;

  tx66_blk_mux #(.LANES(LANES)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot     (slot),
    .empty    (src_empty),
    .src_data (src_data),
    .data     (snk_data),
    .pop      (src_pop),
    .err      (err_underflow)
  );

  // R6: a pop only happens on a data slot with a word available
  p_pop_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> (snk_valid && !snk_am && !src_empty));
  // R3: data paused while valid is low
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !snk_valid |-> $stable(snk_data));
  // R7: marker cycles consume nothing
  p_am_nopop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snk_am |-> !src_pop);
  // R5: valid is never high while disabled
  p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !snk_valid);
endmodule

// File: tb/test_tx66_blk_source.sv
module test_tx66_blk_source;
  localparam int LANES = 4;
  localparam int W     = 66 * LANES;
  localparam int MAXL  = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [3:0]     cfg_latency = 4'd1;
  logic [16:0]    cfg_period = 17'd9;
  logic [3:0]     cfg_burst = 4'd5;
  logic [W-1:0]   src_data = '0;
  logic           src_empty = 1'b1;
  logic           src_pop;
  logic           snk_ready = 1'b0;
  logic           snk_valid;
  logic [W-1:0]   snk_data;
  logic           snk_am;
  logic           err_underflow;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  tx66_blk_source i_tx66_blk_source (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_latency(cfg_latency), .cfg_period(cfg_period), .cfg_burst(cfg_burst),
    .src_data(src_data), .src_empty(src_empty), .src_pop(src_pop),
    .snk_ready(snk_ready), .snk_valid(snk_valid), .snk_data(snk_data),
    .snk_am(snk_am), .err_underflow(err_underflow)
  );

  // model state
  logic [MAXL-1:0] m_hist = '0;
  int m_lat = 1, m_per = 81915, m_burst = 5, m_cnt = 0, seq = 0;
  logic m_err = 1'b0;
  logic [W-1:0] m_last = '0;

  function automatic logic [W-1:0] word(int s);
    logic [W-1:0] w;
    for (int k = 0; k < LANES; k++) w[66*k +: 66] = {32'(s), 16'(k), 16'hC0DE, 2'b01};
    return w;
  endfunction

  function automatic logic [W-1:0] idle4();
    logic [W-1:0] w;
    for (int k = 0; k < LANES; k++) w[66*k +: 66] = {56'h0, 8'h1E, 2'b10};
    return w;
  endfunction

  function automatic int clampl(int v);
    if (v == 0) return 1;
    if (v > MAXL) return MAXL;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(bit r, bit e, bit emp);
    bit ev, eam, slot, epop;
    logic [W-1:0] edata;
    string dreq;
    @(negedge clk);
    snk_ready = r; en = e; src_empty = emp; src_data = word(seq);
    #1;
    ev    = e && m_hist[m_lat-1];
    eam   = (m_cnt < m_burst);
    slot  = ev && !eam;
    epop  = slot && !emp;
    edata = slot ? (emp ? idle4() : word(seq)) : m_last;
    dreq  = slot ? (emp ? "R8 idle" : "R1/R6 data") : (ev ? "R7 am hold" : "R3 hold");
    check(snk_valid == ev, e ? "R2 valid" : "R5 valid", W'(snk_valid), W'(ev));
    check(snk_am == eam, "R4 am", W'(snk_am), W'(eam));
    check(src_pop == epop, "R6 pop", W'(src_pop), W'(epop));
    check(snk_data == edata, dreq, snk_data, edata);
    check(err_underflow == m_err, "R8 err", W'(err_underflow), W'(m_err));
    m_last = edata;
    if (epop) seq++;
    if (slot && emp) m_err = 1'b1;
    if (!e) begin
      m_hist = '0; m_cnt = 0;
      m_lat = clampl(int'(cfg_latency)); m_per = int'(cfg_period); m_burst = int'(cfg_burst);
    end else begin
      if (ev) m_cnt = (m_cnt == m_per - 1) ? 0 : m_cnt + 1;
      m_hist = {m_hist[MAXL-2:0], r};
    end
  endtask

  task automatic segment(int lat, int per, int burst, int n, int mode);
    bit r, emp;
    cfg_latency = 4'(lat); cfg_period = 17'(per); cfg_burst = 4'(burst);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: begin r = ((i/3 + lat) % 4) != 0; emp = (i % 11) == 7; end
        1: begin r = (i % 97) >= 3;          emp = (i % 53) == 0; end
        default: begin r = i[0];             emp = (i % 5) == 0; end
      endcase
      step(r, 1'b1, emp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    check(snk_valid == 1'b0, "R10 valid", W'(snk_valid), '0);
    check(src_pop == 1'b0, "R10 pop", W'(src_pop), '0);
    check(err_underflow == 1'b0, "R10 err", W'(err_underflow), '0);
    check(snk_data == '0, "R10 data", snk_data, '0);
    check(snk_am == 1'b1, "R10 am", W'(snk_am), W'(1));
    @(negedge clk); rst_n = 1'b1;
    // R2 latency sweep including clamp edges 0 and 11..12
    for (int l = 0; l <= 12; l++) segment(l, 9, 5, 60, l % 3);
    // R4 period edge cases
    segment(2, 2, 1, 80, 2);
    segment(3, 315, 5, 1300, 1);
    // R9: change configuration while enabled; latched values stay in force
    segment(4, 7, 2, 20, 0);
    cfg_latency = 4'd9; cfg_period = 17'd3; cfg_burst = 4'd1;
    for (int i = 0; i < 40; i++) step(i % 7 != 0, 1'b1, i % 13 == 5);
    check(m_lat == 4 && m_per == 7, "R9 latched", W'(m_lat), W'(4));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule